// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers twelve interrupt requests from the peripherals of a small 8-bit microcontroller. The sources are a USB bus reset, two periodic timers, five USB endpoint events spread over two device addresses, a hub event, a DAC event, a GPIO event and an I2C event. Each request pulse is caught in a sticky pending flop. Each pending flop is masked by its own enable bit. The enable bits live in two byte-wide registers on a simple register bus.

A fixed-priority encoder chooses the enabled pending source with the lowest number and presents its program-memory vector to the CPU. Each vector slot is two bytes, so source n maps to address 2·n. Address 0x0000 is left free for the reset entry point.

When the CPU acknowledges, only the chosen source's pending flop is cleared, and the global interrupt enable drops. The CPU's disable, enable and return-from-interrupt strobes also drive the global enable. A sense output shows whether any enabled request is waiting, whatever the state of the global enable.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every pending flop, both enable registers and the global enable are 0. As a result irqOut, irqSense, globalEn and vecAddr are all 0.
- R2: A 1 on reqIn bit n-1 at a clock edge sets the pending flop of source n (1 = bus reset … 12 = I2C). The flop stays set over any number of idle cycles until that source is acknowledged.
- R3: Among the sources that are both pending and enabled, the lowest-numbered one wins. vecAddr then equals 2·n, which lies in the range 0x0002 to 0x0018. vecAddr is 0x0000 exactly when no source is both pending and enabled.
- R4: Enable register 0x20 holds sources 1 to 8, with bit b enabling source b+1. Register 0x21 holds sources 9 to 12 in bits 0 to 3, and its bits 4 to 7 always read 0. A write with regWe takes effect at the next edge. regRdata returns the addressed register combinationally and returns 0 for any other address. Writes to other addresses change nothing.
- R5: An acknowledge clears only the pending flop of the current winner. All other pending flops are kept. An acknowledge while no source is both enabled and pending clears no pending flop.
- R6: If a source's request arrives on the same edge as the acknowledge that clears it, the request wins and the flop stays set.
- R7: Clearing a source's enable bit masks the source but keeps its pending flop. Once the bit is set again, the source competes again.
- R8: eiStrobe or retiStrobe sets globalEn. diStrobe or ackIn clears it. When a set and a clear come on the same edge, the set wins.
- R9: irqSense is 1 whenever any source is both enabled and pending, whatever the value of globalEn. irqOut is 1 only when irqSense and globalEn are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 12 | Request pulses; bit n-1 belongs to source n |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for both write and read |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data of the addressed enable register |
| ackIn | input | 1 | CPU takes the presented vector |
| diStrobe | input | 1 | Disable-interrupts instruction strobe |
| eiStrobe | input | 1 | Enable-interrupts instruction strobe |
| retiStrobe | input | 1 | Return-from-interrupt strobe |
| irqOut | output | 1 | Interrupt request to the CPU |
| irqSense | output | 1 | Some enabled request is pending |
| globalEn | output | 1 | Global interrupt enable state |
| vecAddr | output | 16 | Vector address of the winning source |

## Verification
A request, an acknowledge or an enable write changes the pending and enable flops at the next rising edge. irqSense, vecAddr and irqOut follow from those flops without further delay. regRdata follows regAddr in the same cycle, and globalEn changes one edge after a strobe. The bench drives every input a quarter period after a rising edge. It reads the flop-driven results a quarter period after the following edge. It reads regRdata one nanosecond after changing the address. The sweeps cover every single source, every pair of sources and a series of pseudo-random masks drained one acknowledge at a time, with each expected vector computed as twice the lowest set position.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic       ack;     // clear the winning pending flop
    logic       wrEn;    // write the selected enable register
    logic       rdHit;   // address selects an enable register
    logic [3:0] sel;     // which enable register
  } dpStrobes_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int VEC_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  dpStrobes_t         stb,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic               anyActive,
  output logic [VEC_W-1:0]   vecAddr
);
  localparam int NREG  = (NUM_SRC + 7) / 8;
  localparam int EN_W  = NREG * 8;
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [EN_W-1:0] IMPL_MASK = {EN_W{1'b1}} >> (EN_W - NUM_SRC);

  logic [EN_W-1:0]    enStore;
  logic [NUM_SRC-1:0] enBits;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] winOH;
  logic [IDX_W-1:0]   winIdx;

  // enable register file, one byte per register
  for (genvar r = 0; r < NREG; r++) begin : g_enReg
    always_ff @(posedge clk) begin
      if (!rstN)
        enStore[r*8 +: 8] <= '0;
      else if (stb.wrEn && stb.sel == 4'(r))
        enStore[r*8 +: 8] <= wdata & IMPL_MASK[r*8 +: 8];
    end
  end

  assign enBits = enStore[NUM_SRC-1:0];

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREG; r++)
      if (stb.rdHit && stb.sel == 4'(r)) rdata = enStore[r*8 +: 8];
  end

  // pending flops: a new request beats the acknowledge clear
  always_ff @(posedge clk) begin
    if (!rstN)
      pending <= '0;
    else
      pending <= reqIn | (pending & ~(winOH & {NUM_SRC{stb.ack}}));
  end

  assign active    = pending & enBits;
  assign anyActive = |active;

  // fixed priority: lowest index wins, so scan downward and keep the last hit
  always_comb begin
    winOH  = '0;
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        winOH    = '0;
        winOH[i] = 1'b1;
        winIdx   = IDX_W'(i);
      end
    end
  end

  assign vecAddr = anyActive ? ((VEC_W'(winIdx) + VEC_W'(1)) << 1) : '0;

  a_r3_vec_range: assert property (@(posedge clk) disable iff (!rstN)
    anyActive |-> (vecAddr[0] == 1'b0 && vecAddr >= VEC_W'(2) &&
                   vecAddr <= VEC_W'(2 * NUM_SRC)));

  a_r6_req_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|reqIn) |=> ((pending & $past(reqIn)) == $past(reqIn)));

  a_r5_win_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && anyActive) |=> ((pending & $past(winOH) & ~$past(reqIn)) == '0));

  a_r5_others_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> ((($past(pending) & ~$past(winOH)) & ~pending) == '0));
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
#(
  parameter int         NUM_SRC = 12,
  parameter logic [7:0] EN_BASE = 8'h20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic       ackIn,
  input  logic       diStrobe,
  input  logic       eiStrobe,
  input  logic       retiStrobe,
  input  logic       anyActive,
  output dpStrobes_t stb,
  output logic       globalEn,
  output logic       irqOut,
  output logic       irqSense
);
  localparam int NREG = (NUM_SRC + 7) / 8;

  logic [8:0] relAddr;
  logic       hit;

  assign relAddr = {1'b0, regAddr} - {1'b0, EN_BASE};
  assign hit     = (regAddr >= EN_BASE) && (relAddr < 9'(NREG));

  always_comb begin
    stb.ack   = ackIn;
    stb.rdHit = hit;
    stb.wrEn  = hit && regWe;
    stb.sel   = 4'(relAddr);
  end

  // set (EI/RETI) wins over clear (DI/acknowledge)
  always_ff @(posedge clk) begin
    if (!rstN)
      globalEn <= 1'b0;
    else if (eiStrobe || retiStrobe)
      globalEn <= 1'b1;
    else if (diStrobe || ackIn)
      globalEn <= 1'b0;
  end

  assign irqSense = anyActive;
  assign irqOut   = globalEn & anyActive;

  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    ((diStrobe || ackIn) && !eiStrobe && !retiStrobe) |=> !globalEn);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (eiStrobe || retiStrobe) |=> globalEn);

  a_r4_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr < EN_BASE)) |-> !stb.wrEn);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int         NUM_SRC = 12,
  parameter int         VEC_W   = 16,
  parameter logic [7:0] EN_BASE = 8'h20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               regWe,
  input  logic [7:0]         regAddr,
  input  logic [7:0]         regWdata,
  output logic [7:0]         regRdata,
  input  logic               ackIn,
  input  logic               diStrobe,
  input  logic               eiStrobe,
  input  logic               retiStrobe,
  output logic               irqOut,
  output logic               irqSense,
  output logic               globalEn,
  output logic [VEC_W-1:0]   vecAddr
);
  dpStrobes_t stb;
  logic       anyActive;

  vic_control #(.NUM_SRC(NUM_SRC), .EN_BASE(EN_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .ackIn(ackIn), .diStrobe(diStrobe), .eiStrobe(eiStrobe),
    .retiStrobe(retiStrobe), .anyActive(anyActive), .stb(stb),
    .globalEn(globalEn), .irqOut(irqOut), .irqSense(irqSense)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .stb(stb), .wdata(regWdata),
    .rdata(regRdata), .anyActive(anyActive), .vecAddr(vecAddr)
  );
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        ackIn = 1'b0, diStrobe = 1'b0, eiStrobe = 1'b0, retiStrobe = 1'b0;
  logic        irqOut, irqSense, globalEn;
  logic [15:0] vecAddr;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ackIn(ackIn),
    .diStrobe(diStrobe), .eiStrobe(eiStrobe), .retiStrobe(retiStrobe),
    .irqOut(irqOut), .irqSense(irqSense), .globalEn(globalEn), .vecAddr(vecAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    chk(req, 32'(regRdata), 32'(exp));
  endtask

  task automatic pulseReq(input logic [N-1:0] m);
    reqIn = m;
    tick();
    reqIn = '0;
  endtask

  task automatic doAck();
    ackIn = 1'b1;
    tick();
    ackIn = 1'b0;
  endtask

  function automatic int lowIdx(input logic [N-1:0] m);
    for (int i = N - 1; i >= 0; i--) if (m[i]) lowIdx = i;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] m;
    logic [N-1:0] lfsr;
    tick(); tick();
    // R1 reset state
    chk("R1 irqOut", 32'(irqOut), 0);
    chk("R1 irqSense", 32'(irqSense), 0);
    chk("R1 globalEn", 32'(globalEn), 0);
    chk("R1 vecAddr", 32'(vecAddr), 0);
    rdChk("R1 en0", 8'h20, 8'h00);
    rdChk("R1 en1", 8'h21, 8'h00);
    rstN = 1'b1;
    tick();

    // R4 register map
    wrReg(8'h20, 8'hA5);
    rdChk("R4 en0 readback", 8'h20, 8'hA5);
    wrReg(8'h21, 8'hFF);
    rdChk("R4 en1 upper bits zero", 8'h21, 8'h0F);
    wrReg(8'h22, 8'h55);
    rdChk("R4 other address reads 0", 8'h22, 8'h00);
    wrReg(8'h1F, 8'h00);
    rdChk("R4 stray write en0", 8'h20, 8'hA5);
    rdChk("R4 stray write en1", 8'h21, 8'h0F);
    wrReg(8'h20, 8'hFF);

    // R2/R3 single sources
    for (int n = 1; n <= N; n++) begin
      pulseReq(N'(1) << (n - 1));
      chk("R3 single sense", 32'(irqSense), 1);
      chk("R3 single vector", 32'(vecAddr), 32'(2 * n));
      doAck();
      chk("R5 single cleared", 32'(vecAddr), 0);
    end
    // R2 stays across idle cycles
    pulseReq(N'(1) << 11);
    for (int k = 0; k < 5; k++) tick();
    chk("R2 held pending", 32'(vecAddr), 32'h18);
    doAck();

    // R3/R5 all pairs
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        pulseReq((N'(1) << a) | (N'(1) << b));
        chk("R3 pair winner", 32'(vecAddr), 32'(2 * (a + 1)));
        doAck();
        chk("R5 pair survivor", 32'(vecAddr), 32'(2 * (b + 1)));
        doAck();
        chk("R5 pair drained", 32'(irqSense), 0);
      end
    end

    // R3/R5 pseudo-random masks drained in order
    lfsr = 12'hA5B;
    for (int t = 0; t < 40; t++) begin
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
      if (lfsr == '0) lfsr = 12'h001;
      m = lfsr;
      pulseReq(m);
      while (m != '0) begin
        chk("R3 mask vector", 32'(vecAddr), 32'(2 * (lowIdx(m) + 1)));
        doAck();
        m = m & (m - N'(1));
      end
      chk("R5 mask drained", 32'(vecAddr), 0);
    end

    // R7 masking keeps pending; R5 ack with nothing active
    wrReg(8'h20, 8'h00);
    pulseReq(N'(1) << 2);
    chk("R7 masked sense", 32'(irqSense), 0);
    chk("R7 masked vector", 32'(vecAddr), 0);
    doAck();
    wrReg(8'h20, 8'hFF);
    chk("R7 restored vector", 32'(vecAddr), 6);
    doAck();
    chk("R5 cleared after restore", 32'(irqSense), 0);

    // R6 request beats acknowledge
    pulseReq(N'(1) << 4);
    chk("R6 setup", 32'(vecAddr), 10);
    ackIn = 1'b1; reqIn = N'(1) << 4;
    tick();
    ackIn = 1'b0; reqIn = '0;
    chk("R6 kept", 32'(vecAddr), 10);
    doAck();
    chk("R6 then cleared", 32'(vecAddr), 0);

    // R8/R9 global enable
    pulseReq(N'(1) << 1);
    chk("R9 sense without enable", 32'(irqSense), 1);
    chk("R9 no irqOut", 32'(irqOut), 0);
    eiStrobe = 1'b1; tick(); eiStrobe = 1'b0;
    chk("R8 ei sets", 32'(globalEn), 1);
    chk("R9 irqOut", 32'(irqOut), 1);
    diStrobe = 1'b1; tick(); diStrobe = 1'b0;
    chk("R8 di clears", 32'(globalEn), 0);
    retiStrobe = 1'b1; tick(); retiStrobe = 1'b0;
    chk("R8 reti sets", 32'(globalEn), 1);
    diStrobe = 1'b1; eiStrobe = 1'b1; tick(); diStrobe = 1'b0; eiStrobe = 1'b0;
    chk("R8 set wins over di", 32'(globalEn), 1);
    doAck();
    chk("R8 ack clears", 32'(globalEn), 0);
    chk("R9 irqOut after ack", 32'(irqOut), 0);
    pulseReq(N'(1) << 7);
    ackIn = 1'b1; eiStrobe = 1'b1; tick(); ackIn = 1'b0; eiStrobe = 1'b0;
    chk("R8 ei wins over ack", 32'(globalEn), 1);
    chk("R5 ack cleared source", 32'(irqOut), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule